// File: doc/BRIEF.md
# Converter Handshake and Echo Sequencer

This block controls an external 8-bit converter pair. It runs the start, end-of-conversion and read handshake of a successive-approximation ADC, and it owns the 8-bit register that feeds a parallel DAC. A conversion begins with a low pulse on the start line. The block then waits until the converter pulls its end-of-conversion line low. It ends the conversion with a low read strobe and takes the data bus value at the moment the strobe is released. The end-of-conversion input passes through a synchronizer, so the wait can last any number of cycles up to a timeout limit, and that number may change from one sample to the next.

While `run_i` is high, `mode_i` selects one of two continuous modes. In echo mode each sample goes unchanged to the DAC, and the next conversion starts straight away. In generator mode the ADC is not used, and the DAC steps through a 64-entry sine table at a rate set by `div_i`. While `run_i` is low, a host can pulse `host_start_i` to take one sample, which is returned on `sample_o`. A change of mode, or a drop of `run_i`, only takes effect once the current sample or table step has finished. No handshake is ever left half done.

Top module: `adc_dac_seq`

## Requirements
- R1: Every conversion starts with `adc_wr_n_o` held low for exactly START_W consecutive cycles, then returned high.
- R2: After the start line is released, the block waits for `adc_int_n_i` low and then drives `adc_rd_n_o` low for exactly RD_W cycles. `adc_wr_n_o` and `adc_rd_n_o` are never low together.
- R3: The result is the `adc_data_i` value present at the clock edge that returns `adc_rd_n_o` high. It appears on `sample_o` with a one-cycle `sample_valid_o` pulse, one cycle after `adc_rd_n_o` rises. Any conversion time that brings `adc_int_n_i` low within TMO_CYC-4 cycles of the start release is accepted.
- R4: If `adc_int_n_i` does not go low within TMO_CYC cycles of the start release, the conversion is dropped. In that case there is no `sample_valid_o`, both strobes stay high, and `timeout_err_o` goes high and stays high until reset.
- R5: In echo mode (`run_i`=1, `mode_i`=0), each sample is written unchanged to `dac_o` in the same cycle it reaches `sample_o`. The next start pulse begins one cycle after `sample_valid_o`.
- R6: In generator mode (`run_i`=1, `mode_i`=1), `dac_o` takes entry k = 128 + round(127·sin(2πk/64)) with k = 0..63 wrapping, one entry every `div_i`+1 cycles. The ADC strobes stay high.
- R7: Each time the generator is entered from idle, it restarts at entry 0.
- R8: A change of `mode_i` takes effect only at the end of the current sample (echo) or table step (generator). A conversion in progress completes and is delivered, and a generator step in progress completes before the first start pulse.
- R9: With `run_i` low, a `host_start_i` pulse performs one conversion that updates `sample_o` and `sample_valid_o` and leaves `dac_o` unchanged. `host_start_i` is ignored while `run_i` is high.
- R10: After reset, both strobes are high, `dac_o` is 0x80, `sample_o` is 0, and `sample_valid_o` and `timeout_err_o` are low.
- R11: With `run_i` low and no host start, the ADC strobes stay high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_i | input | 1 | Enables continuous operation in the mode selected by mode_i |
| mode_i | input | 1 | 0 = echo, 1 = sine generator |
| host_start_i | input | 1 | Single-conversion request, honoured only while run_i is low and idle |
| div_i | input | DIV_W | Generator step period minus one, in cycles |
| adc_int_n_i | input | 1 | Converter end-of-conversion, active low, asynchronous |
| adc_data_i | input | 8 | Converter result bus |
| adc_wr_n_o | output | 1 | Converter start strobe, active low |
| adc_rd_n_o | output | 1 | Converter read strobe, active low |
| dac_o | output | 8 | DAC code register |
| sample_o | output | 8 | Last captured sample |
| sample_valid_o | output | 1 | One-cycle pulse when sample_o is refreshed |
| timeout_err_o | output | 1 | Sticky conversion-timeout flag |

## Verification
If the handshake state goes wrong, the strobes show it within a few cycles: a strobe width is off, the two strobes overlap, or the start pulse after an echo sample comes late. If the capture point is wrong, `sample_o` differs from the responder value, because the bench inverts the bus one cycle after the read strobe rises. A wrong table index or divider count shows at the next generator step as a wrong DAC code or a wrong interval. A mode that changes too early shows up as a missing sample or as a start pulse that lands inside a generator step.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    localparam int SMP_W     = 8;
    localparam int TBL_DEPTH = 64;
    localparam int TBL_IDX_W = $clog2(TBL_DEPTH);

    localparam logic [SMP_W-1:0] MID_CODE = 8'h80;
    localparam logic MODE_ECHO = 1'b0;
    localparam logic MODE_GEN  = 1'b1;

    typedef enum logic [1:0] {
        HS_IDLE,
        HS_START,
        HS_WAIT,
        HS_READ
    } hs_st_e;

    typedef enum logic [1:0] {
        T_IDLE,
        T_ECHO,
        T_SINGLE,
        T_GEN
    } top_st_e;

    typedef struct packed {
        top_st_e              st;
        logic [TBL_IDX_W-1:0] idx;
        logic [SMP_W-1:0]     dac;
        logic [SMP_W-1:0]     smp;
        logic                 vld;
        logic                 err;
    } top_reg_t;

endpackage

// File: rtl/sine_rom.sv
module sine_rom
    import adc_seq_pkg::*;
(
    input  logic [TBL_IDX_W-1:0] idx_i,
    output logic [SMP_W-1:0]     val_o
);
    localparam int QW = TBL_IDX_W - 2;
    localparam int QN = TBL_DEPTH / 4;

    // Quarter-wave magnitudes: round(127 * sin(pi*k/32)), k = 0..16
    localparam logic [6:0] QTR [QN+1] = '{
        7'd0,   7'd12,  7'd25,  7'd37,  7'd49,  7'd60,
        7'd71,  7'd81,  7'd90,  7'd98,  7'd106, 7'd112,
        7'd117, 7'd122, 7'd125, 7'd126, 7'd127
    };

    logic [1:0]    quad;
    logic [QW-1:0] pos;
    logic [QW:0]   qidx;
    logic [6:0]    mag;

    always_comb begin
        quad  = idx_i[TBL_IDX_W-1 -: 2];
        pos   = idx_i[QW-1:0];
        qidx  = quad[0] ? ((QW+1)'(QN) - {1'b0, pos}) : {1'b0, pos};
        mag   = QTR[qidx];
        val_o = quad[1] ? (MID_CODE - {1'b0, mag}) : (MID_CODE + {1'b0, mag});
    end

endmodule

// File: rtl/step_divider.sv
module step_divider #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o
);
    logic [DIV_W-1:0] cnt_d, cnt_q;

    always_comb begin
        tick_o = en_i && (cnt_q >= div_i);
        if (!en_i || tick_o) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

endmodule

// File: rtl/adc_handshake.sv
module adc_handshake
    import adc_seq_pkg::*;
#(
    parameter int START_W     = 3,
    parameter int RD_W        = 2,
    parameter int TMO_CYC     = 2048,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go_i,
    input  logic             int_n_i,
    input  logic [SMP_W-1:0] data_i,
    output logic             wr_n_o,
    output logic             rd_n_o,
    output logic             done_o,
    output logic             tmo_o,
    output logic [SMP_W-1:0] data_o
);
    localparam int CNT_MAX = (TMO_CYC > START_W) ?
                             ((TMO_CYC > RD_W) ? TMO_CYC : RD_W) :
                             ((START_W > RD_W) ? START_W : RD_W);
    localparam int CNT_W = $clog2(CNT_MAX + 1);

    typedef struct packed {
        hs_st_e           st;
        logic [CNT_W-1:0] cnt;
        logic             wr_n;
        logic             rd_n;
        logic             done;
        logic             tmo;
        logic [SMP_W-1:0] data;
    } hs_reg_t;

    localparam hs_reg_t HS_RST = '{st: HS_IDLE, cnt: '0, wr_n: 1'b1, rd_n: 1'b1,
                                   done: 1'b0, tmo: 1'b0, data: '0};

    hs_reg_t r_d, r_q;
    logic    eoc;

    // end-of-conversion synchronizer, depth picked by parameter
    generate
        if (SYNC_STAGES < 2) begin : g_sync1
            logic s_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) s_q <= 1'b1;
                else        s_q <= int_n_i;
            end
            assign eoc = ~s_q;
        end else begin : g_syncn
            logic [SYNC_STAGES-1:0] s_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) s_q <= '1;
                else        s_q <= {s_q[SYNC_STAGES-2:0], int_n_i};
            end
            assign eoc = ~s_q[SYNC_STAGES-1];
        end
    endgenerate

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        r_d.tmo  = 1'b0;
        case (r_q.st)
            HS_IDLE: begin
                if (go_i) begin
                    r_d.st   = HS_START;
                    r_d.wr_n = 1'b0;
                    r_d.cnt  = '0;
                end
            end
            HS_START: begin
                if (r_q.cnt == CNT_W'(START_W - 1)) begin
                    r_d.st   = HS_WAIT;
                    r_d.wr_n = 1'b1;
                    r_d.cnt  = '0;
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            HS_WAIT: begin
                if (eoc) begin
                    r_d.st   = HS_READ;
                    r_d.rd_n = 1'b0;
                    r_d.cnt  = '0;
                end else if (r_q.cnt == CNT_W'(TMO_CYC - 1)) begin
                    r_d.st  = HS_IDLE;
                    r_d.tmo = 1'b1;
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            HS_READ: begin
                if (r_q.cnt == CNT_W'(RD_W - 1)) begin
                    r_d.st   = HS_IDLE;
                    r_d.rd_n = 1'b1;
                    r_d.data = data_i;
                    r_d.done = 1'b1;
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            default: r_d = HS_RST;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= HS_RST;
        else        r_q <= r_d;
    end

    assign wr_n_o = r_q.wr_n;
    assign rd_n_o = r_q.rd_n;
    assign done_o = r_q.done;
    assign tmo_o  = r_q.tmo;
    assign data_o = r_q.data;

    // R1
    wr_from_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(r_q.wr_n) |-> $past(go_i));

    // R2
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!r_q.wr_n && !r_q.rd_n));

    // R3
    done_at_rd_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.done |-> $rose(r_q.rd_n));

    // R4
    tmo_lines_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.tmo |-> (r_q.wr_n && r_q.rd_n && !r_q.done));

endmodule

// File: rtl/adc_dac_seq.sv
module adc_dac_seq
    import adc_seq_pkg::*;
#(
    parameter int START_W     = 3,
    parameter int RD_W        = 2,
    parameter int TMO_CYC     = 2048,
    parameter int SYNC_STAGES = 2,
    parameter int DIV_W       = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             mode_i,
    input  logic             host_start_i,
    input  logic [DIV_W-1:0] div_i,
    input  logic             adc_int_n_i,
    input  logic [7:0]       adc_data_i,
    output logic             adc_wr_n_o,
    output logic             adc_rd_n_o,
    output logic [7:0]       dac_o,
    output logic [7:0]       sample_o,
    output logic             sample_valid_o,
    output logic             timeout_err_o
);
    localparam top_reg_t TOP_RST = '{st: T_IDLE, idx: '0, dac: MID_CODE,
                                     smp: '0, vld: 1'b0, err: 1'b0};

    top_reg_t         r_d, r_q;
    logic             go;
    logic             hs_done, hs_tmo;
    logic [SMP_W-1:0] hs_data;
    logic             tick;
    logic [SMP_W-1:0] tbl_val;

    adc_handshake #(
        .START_W     (START_W),
        .RD_W        (RD_W),
        .TMO_CYC     (TMO_CYC),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_hs (
        .clk     (clk),
        .rst_n   (rst_n),
        .go_i    (go),
        .int_n_i (adc_int_n_i),
        .data_i  (adc_data_i),
        .wr_n_o  (adc_wr_n_o),
        .rd_n_o  (adc_rd_n_o),
        .done_o  (hs_done),
        .tmo_o   (hs_tmo),
        .data_o  (hs_data)
    );

    step_divider #(.DIV_W(DIV_W)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (r_q.st == T_GEN),
        .div_i  (div_i),
        .tick_o (tick)
    );

    sine_rom u_rom (
        .idx_i (r_q.idx),
        .val_o (tbl_val)
    );

    always_comb begin
        r_d     = r_q;
        r_d.vld = 1'b0;
        go      = 1'b0;
        if (hs_tmo) r_d.err = 1'b1;
        case (r_q.st)
            T_IDLE: begin
                if (run_i) begin
                    if (mode_i == MODE_GEN) begin
                        r_d.st  = T_GEN;
                        r_d.idx = '0;
                    end else begin
                        go     = 1'b1;
                        r_d.st = T_ECHO;
                    end
                end else if (host_start_i) begin
                    go     = 1'b1;
                    r_d.st = T_SINGLE;
                end
            end
            T_ECHO: begin
                if (hs_done) begin
                    r_d.smp = hs_data;
                    r_d.dac = hs_data;
                    r_d.vld = 1'b1;
                    r_d.st  = T_IDLE;
                end else if (hs_tmo) begin
                    r_d.st = T_IDLE;
                end
            end
            T_SINGLE: begin
                if (hs_done) begin
                    r_d.smp = hs_data;
                    r_d.vld = 1'b1;
                    r_d.st  = T_IDLE;
                end else if (hs_tmo) begin
                    r_d.st = T_IDLE;
                end
            end
            T_GEN: begin
                if (tick) begin
                    r_d.dac = tbl_val;
                    r_d.idx = r_q.idx + 1'b1;
                    if (!(run_i && mode_i == MODE_GEN)) r_d.st = T_IDLE;
                end
            end
            default: r_d = TOP_RST;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= TOP_RST;
        else        r_q <= r_d;
    end

    assign dac_o          = r_q.dac;
    assign sample_o       = r_q.smp;
    assign sample_valid_o = r_q.vld;
    assign timeout_err_o  = r_q.err;

    // R4
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.err |=> r_q.err);

    // R9
    single_dac_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == T_SINGLE) |=> $stable(r_q.dac));

    // R6
    gen_adc_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == T_GEN) |-> (adc_wr_n_o && adc_rd_n_o));

    // R5
    echo_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_done && r_q.st == T_ECHO) |=> (r_q.vld && r_q.dac == r_q.smp));

endmodule

// File: tb/adc_dac_seq_bench.sv
module adc_dac_seq_bench;
    localparam int CLK_PERIOD  = 10;
    localparam int START_W     = 3;
    localparam int RD_W        = 2;
    localparam int TMO_CYC     = 150;
    localparam int SYNC_STAGES = 2;
    localparam int DIV_W       = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             run_i = 1'b0;
    logic             mode_i = 1'b0;
    logic             host_start_i = 1'b0;
    logic [DIV_W-1:0] div_i = '0;
    logic             adc_int_n = 1'b1;
    logic [7:0]       adc_data = 8'h00;
    logic             adc_wr_n, adc_rd_n;
    logic [7:0]       dac_o, sample_o;
    logic             sample_valid_o, timeout_err_o;

    adc_dac_seq #(
        .START_W(START_W), .RD_W(RD_W), .TMO_CYC(TMO_CYC),
        .SYNC_STAGES(SYNC_STAGES), .DIV_W(DIV_W)
    ) u_adc_dac_seq (
        .clk(clk), .rst_n(rst_n), .run_i(run_i), .mode_i(mode_i),
        .host_start_i(host_start_i), .div_i(div_i),
        .adc_int_n_i(adc_int_n), .adc_data_i(adc_data),
        .adc_wr_n_o(adc_wr_n), .adc_rd_n_o(adc_rd_n),
        .dac_o(dac_o), .sample_o(sample_o),
        .sample_valid_o(sample_valid_o), .timeout_err_o(timeout_err_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int failures = 0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int tbl(input int k);
        real s;
        int  mag;
        s   = $sin(2.0 * 3.14159265358979 * real'(k) / 64.0);
        mag = $rtoi(127.0 * ((s < 0.0) ? -s : s) + 0.5);
        return (s < 0.0) ? 128 - mag : 128 + mag;
    endfunction

    // converter responder
    bit       resp_dead = 0;
    int       fixed_delay = 0;
    int       resp_n = 0;
    int       d;
    logic [7:0] last_val = 8'h00;

    initial begin
        wait (rst_n === 1'b1);
        forever begin
            @(posedge adc_wr_n);
            if (!resp_dead) begin
                d = (fixed_delay > 0) ? fixed_delay : 4 + (resp_n * 29) % 90;
                repeat (d) @(negedge clk);
                last_val  = 8'((resp_n * 73 + 5) & 255);
                adc_data  = last_val;
                adc_int_n = 1'b0;
                resp_n++;
                @(negedge adc_rd_n);
                @(negedge clk);
                adc_int_n = 1'b1;
                @(posedge adc_rd_n);
                @(negedge clk);
                adc_data = ~last_val;
            end
        end
    end

    // port monitor
    int  cyc = 0;
    int  wr_run = 0, rd_run = 0, last_wr_width = 0, last_rd_width = 0;
    int  wr_fall_cnt = 0, rd_fall_cnt = 0, wr_fall_cyc = 0, rd_rise_cyc = 0;
    int  both_low_cnt = 0, valid_cnt = 0, valid_cyc = 0;
    int  dac_chg_cnt = 0, dac_chg_cyc = 0;
    bit  echo_chk = 0, expect_restart = 0, gen_chk = 0, gen_first = 0;
    int  gen_e = 0, gen_div = 0;
    logic wr_prev = 1'b1, rd_prev = 1'b1;
    logic [7:0] dac_prev = 8'h80;

    always @(negedge clk) begin
        if (rst_n) begin
            cyc++;
            if (!adc_wr_n && !adc_rd_n) both_low_cnt++;
            if (!adc_wr_n) wr_run++;
            if (wr_prev && !adc_wr_n) begin
                wr_fall_cnt++;
                wr_fall_cyc = cyc;
                if (expect_restart) begin
                    // R5: next start one cycle after the sample
                    check(cyc - valid_cyc == 1, "R5 restart gap", cyc - valid_cyc, 1);
                    expect_restart = 0;
                end
            end
            if (!wr_prev && adc_wr_n) begin
                last_wr_width = wr_run;
                wr_run = 0;
            end
            if (!adc_rd_n) rd_run++;
            if (rd_prev && !adc_rd_n) rd_fall_cnt++;
            if (!rd_prev && adc_rd_n) begin
                last_rd_width = rd_run;
                rd_run = 0;
                rd_rise_cyc = cyc;
            end
            if (sample_valid_o) begin
                check(last_wr_width == START_W, "R1 start width", last_wr_width, START_W);
                check(last_rd_width == RD_W, "R2 read width", last_rd_width, RD_W);
                check(sample_o == last_val, "R3 captured value", sample_o, last_val);
                check(cyc - rd_rise_cyc == 1, "R3 valid latency", cyc - rd_rise_cyc, 1);
                if (echo_chk) begin
                    check(dac_o == sample_o, "R5 echo copy", dac_o, sample_o);
                    if (run_i) expect_restart = 1;
                end
                valid_cyc = cyc;
                valid_cnt++;
            end
            if (dac_o != dac_prev) begin
                if (gen_chk) begin
                    if (gen_first)
                        check(dac_o == 8'(tbl(gen_e)), "R7 first entry", dac_o, tbl(gen_e));
                    else begin
                        check(dac_o == 8'(tbl(gen_e)), "R6 table value", dac_o, tbl(gen_e));
                        check(cyc - dac_chg_cyc == gen_div + 1, "R6 step period",
                              cyc - dac_chg_cyc, gen_div + 1);
                    end
                    gen_first = 0;
                    gen_e = (gen_e + 1) % 64;
                end
                dac_chg_cnt++;
                dac_chg_cyc = cyc;
            end
            wr_prev  = adc_wr_n;
            rd_prev  = adc_rd_n;
            dac_prev = dac_o;
        end
    end

    task automatic pulse_host;
        @(negedge clk);
        host_start_i = 1'b1;
        @(negedge clk);
        host_start_i = 1'b0;
    endtask

    task automatic finish_run;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int v, w, c, sw_cyc;
        repeat (5) @(negedge clk);
        // R10 reset state
        check(adc_wr_n == 1'b1, "R10 wr_n reset", adc_wr_n, 1);
        check(adc_rd_n == 1'b1, "R10 rd_n reset", adc_rd_n, 1);
        check(dac_o == 8'h80, "R10 dac reset", dac_o, 128);
        check(sample_o == 8'h00, "R10 sample reset", sample_o, 0);
        check(!sample_valid_o && !timeout_err_o, "R10 flags reset",
              {sample_valid_o, timeout_err_o}, 0);
        rst_n = 1'b1;

        // R11 idle
        repeat (40) @(negedge clk);
        check(wr_fall_cnt == 0 && rd_fall_cnt == 0, "R11 idle strobes",
              wr_fall_cnt + rd_fall_cnt, 0);

        // R9 single conversions, varying conversion times
        for (int i = 0; i < 5; i++) begin
            v = valid_cnt;
            pulse_host();
            wait (valid_cnt == v + 1);
            @(negedge clk);
            check(dac_o == 8'h80, "R9 dac untouched", dac_o, 128);
        end
        // R3 longest accepted conversion
        fixed_delay = TMO_CYC - 8;
        v = valid_cnt;
        pulse_host();
        wait (valid_cnt == v + 1);
        fixed_delay = 0;
        check(timeout_err_o == 1'b0, "R3 long conversion no error", timeout_err_o, 0);

        // R4 timeout
        resp_dead = 1;
        v = valid_cnt;
        pulse_host();
        repeat (TMO_CYC + 30) @(negedge clk);
        check(valid_cnt == v, "R4 no sample on timeout", valid_cnt, v);
        check(timeout_err_o == 1'b1, "R4 error set", timeout_err_o, 1);
        check(adc_wr_n && adc_rd_n, "R4 strobes released", {adc_wr_n, adc_rd_n}, 3);
        resp_dead = 0;
        pulse_host();
        wait (valid_cnt == v + 1);
        @(negedge clk);
        check(timeout_err_o == 1'b1, "R4 error sticky", timeout_err_o, 1);

        // R5 echo sweep
        echo_chk = 1;
        mode_i = 1'b0;
        v = valid_cnt;
        run_i = 1'b1;
        wait (valid_cnt == v + 24);
        run_i = 1'b0;
        expect_restart = 0;
        repeat (TMO_CYC + 20) @(negedge clk);
        echo_chk = 0;

        // R6 R7 R9 generator sweep over dividers
        for (int k = 0; k < 3; k++) begin
            gen_div = (k == 0) ? 0 : (k == 1) ? 1 : 5;
            div_i = DIV_W'(gen_div);
            gen_e = (dac_o == 8'(tbl(0))) ? 1 : 0;
            gen_first = 1;
            gen_chk = 1;
            w = wr_fall_cnt;
            v = valid_cnt;
            c = dac_chg_cnt;
            mode_i = 1'b1;
            run_i = 1'b1;
            pulse_host();
            pulse_host();
            wait (dac_chg_cnt == c + 70);
            run_i = 1'b0;
            repeat (20) @(negedge clk);
            gen_chk = 0;
            check(wr_fall_cnt == w, "R6 no adc start in generator", wr_fall_cnt, w);
            check(valid_cnt == v, "R9 host start ignored while running", valid_cnt, v);
        end

        // R8 echo to generator mid conversion
        mode_i = 1'b0;
        w = wr_fall_cnt;
        v = valid_cnt;
        div_i = 8'd3;
        run_i = 1'b1;
        wait (wr_fall_cnt == w + 1);
        @(negedge clk);
        mode_i = 1'b1;
        repeat (TMO_CYC + 50) @(negedge clk);
        check(valid_cnt == v + 1, "R8 conversion completes", valid_cnt, v + 1);
        check(wr_fall_cnt == w + 1, "R8 no further start", wr_fall_cnt, w + 1);
        run_i = 1'b0;
        repeat (20) @(negedge clk);

        // R8 generator to echo mid step
        div_i = 8'd40;
        c = dac_chg_cnt;
        mode_i = 1'b1;
        run_i = 1'b1;
        wait (dac_chg_cnt == c + 3);
        repeat (10) @(negedge clk);
        mode_i = 1'b0;
        sw_cyc = cyc;
        w = wr_fall_cnt;
        c = dac_chg_cnt;
        wait (wr_fall_cnt == w + 1);
        check(dac_chg_cnt == c + 1, "R8 step finished first", dac_chg_cnt, c + 1);
        check(wr_fall_cyc - dac_chg_cyc == 1, "R8 start after step",
              wr_fall_cyc - dac_chg_cyc, 1);
        check(wr_fall_cyc - sw_cyc > 20, "R8 not early", wr_fall_cyc - sw_cyc, 21);
        run_i = 1'b0;
        repeat (TMO_CYC + 20) @(negedge clk);

        // R2 strobe exclusion across the whole run
        check(both_low_cnt == 0, "R2 strobes never both low", both_low_cnt, 0);
        finish_run();
    end

endmodule